// File: doc/BRIEF.md
# MII Receive Delimiter Finder and Byte Framer

This block sits right behind the 4-bit receive data pins of a media-independent interface. While the receive data-valid input is high it looks at the incoming nibbles and searches for the start-of-frame delimiter. It accepts any run of preamble nibbles, including none at all. Once the delimiter has been seen, it packs nibble pairs into bytes and hands them on as beats. Each beat carries a start marker, an end marker and an alignment-error flag. A preamble that contains two consecutive zero bits is treated as corrupt, and the rest of that frame is thrown away.

Beats leave through a valid/ready stream. The incoming line cannot be paused, so a small beat queue absorbs back-pressure. A beat holds steady while valid is high and ready is low. One beat moves on each cycle in which both are high. When the queue is full, a newly formed beat is discarded, and a one-cycle drop pulse reports the loss.

Top module: `mii_rx_framer`

## Requirements
- R1: After reset, `out_valid` and `ovf_drop` are 0.
- R2: Bits arrive lsb first, so the first nibble after the delimiter is bits 3:0 of a data byte and the second nibble is bits 7:4.
- R3: The delimiter is nibble 0x5 directly followed by nibble 0xD. Any number of 0x5 nibbles (zero or more) may precede it. No beat is produced for nibbles seen before the delimiter completes.
- R4: Before the delimiter, two consecutive 0 bits abort the frame and no beats are produced for it until data-valid falls. The pair may lie inside one nibble (lsb first) or span the msb of one nibble and the lsb of the next. The first bit after data-valid rises has no predecessor.
- R5: The first data byte of a frame has `out_sof`=1, and every later byte has `out_sof`=0.
- R6: The last complete byte before data-valid falls has `out_eof`=1, and every other byte has `out_eof`=0.
- R7: An odd trailing nibble is discarded and sets `out_err`=1 on the end beat. `out_err` is 0 on every other beat. A frame with no complete data byte produces no beat.
- R8: A low data-valid restarts the delimiter search, so each frame is handled on its own, even after only one idle cycle.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and all beat fields stay unchanged.
- R10: Beats leave in the order they were formed. A beat formed while the queue holds `FIFO_DEPTH` beats is dropped, and `ovf_drop` is high for exactly one cycle per dropped beat, in the next cycle.
- R11: A nibble that is free of 00 bit pairs but is neither the preamble value nor a completing 0xD keeps the search going. A 0xD that does not directly follow a 0x5 does not complete the delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mii_dv | input | 1 | Receive data valid |
| mii_rxd | input | 4 | Receive data nibble |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_err | output | 1 | Odd trailing nibble at frame end |
| ovf_drop | output | 1 | A beat was dropped because the queue was full |

## Verification
The bench builds the block with its default parameters: a queue depth of 4 and a delimiter of 0x5 followed by 0xD. With a depth of only four beats, a single ten-byte frame held against a low ready fills the queue and forces six drops, which makes the overflow path easy to reach. The random traffic never lowers ready for two cycles in a row, and at most one beat is formed every two cycles, so outside that directed case the queue never fills and every formed beat can be predicted.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sof;
    logic              eof;
    logic              err;
  } rx_beat_t;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HALF = 2'd1,
    ST_DATA = 2'd2,
    ST_DROP = 2'd3
  } hunt_st_t;
endpackage

// File: rtl/mii_sfd_hunt.sv
module mii_sfd_hunt
  import mii_rx_pkg::*;
#(
  parameter logic [NIB_W-1:0] SFD_LO = 4'h5,
  parameter logic [NIB_W-1:0] SFD_HI = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dv,
  input  logic [NIB_W-1:0] rxd,
  output logic             in_data
);
  hunt_st_t st_q, st_nx;
  logic     prev_bit_q;
  logic     pair00;

  // two adjacent zero bits in lsb-first order, including the boundary bit
  always_comb begin
    pair00 = !prev_bit_q && !rxd[0];
    for (int i = 1; i < NIB_W; i++) begin
      if (!rxd[i-1] && !rxd[i]) pair00 = 1'b1;
    end
  end

  always_comb begin
    st_nx = st_q;
    if (!dv) begin
      st_nx = ST_HUNT;
    end else begin
      unique case (st_q)
        ST_HUNT, ST_HALF: begin
          if (pair00)                           st_nx = ST_DROP;
          else if (st_q == ST_HALF && rxd == SFD_HI) st_nx = ST_DATA;
          else if (rxd == SFD_LO)               st_nx = ST_HALF;
          else                                  st_nx = ST_HUNT;
        end
        ST_DATA: st_nx = ST_DATA;
        ST_DROP: st_nx = ST_DROP;
        default: st_nx = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_HUNT;
      prev_bit_q <= 1'b1;
    end else begin
      st_q       <= st_nx;
      prev_bit_q <= dv ? rxd[NIB_W-1] : 1'b1;
    end
  end

  assign in_data = (st_q == ST_DATA);

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP && dv) |=> (st_q == ST_DROP)); // R4
  AST_DATA_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && dv) |=> in_data); // R3
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !dv |=> (st_q == ST_HUNT)); // R8
endmodule

// File: rtl/mii_nib_pack.sv
module mii_nib_pack
  import mii_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dv,
  input  logic             in_data,
  input  logic [NIB_W-1:0] nib,
  output logic             push,
  output rx_beat_t         beat
);
  logic [NIB_W-1:0]  lo_q;
  logic              half_q;
  logic              pend_vld_q;
  logic [BYTE_W-1:0] pend_q;
  logic              pend_sof_q;
  logic              first_q;
  logic              take, fin;

  assign take = in_data && dv;
  assign fin  = in_data && !dv;

  // one byte is held back so the end marker can be attached when dv falls
  always_comb begin
    push      = pend_vld_q && ((take && half_q) || fin);
    beat.data = pend_q;
    beat.sof  = pend_sof_q;
    beat.eof  = fin;
    beat.err  = fin && half_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q       <= '0;
      half_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
      pend_sof_q <= 1'b0;
      first_q    <= 1'b1;
    end else if (take) begin
      if (!half_q) begin
        lo_q   <= nib;
        half_q <= 1'b1;
      end else begin
        half_q     <= 1'b0;
        pend_q     <= {nib, lo_q};
        pend_vld_q <= 1'b1;
        pend_sof_q <= first_q;
        first_q    <= 1'b0;
      end
    end else begin
      half_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      first_q    <= 1'b1;
    end
  end

  AST_ERR_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (push && beat.err) |-> beat.eof); // R7
  AST_EOF_AT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && beat.eof) |-> !dv); // R6
endmodule

// File: rtl/mii_beat_fifo.sv
module mii_beat_fifo
  import mii_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_beat_t din,
  output logic     out_valid,
  input  logic     out_ready,
  output rx_beat_t dout,
  output logic     ovf_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLC = (AW + 1)'(DEPTH);

  rx_beat_t      slot [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          full, wr_en, rd_en;

  assign full      = (count == FULLC);
  assign wr_en     = push && !full;
  assign out_valid = (count != '0);
  assign rd_en     = out_valid && out_ready;
  assign dout      = slot[rd_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                         slot[g] <= '0;
      else if (wr_en && wr_ptr == AW'(g)) slot[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      ovf_drop <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      unique case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      ovf_drop <= push && full;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC); // R10
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_drop |-> ($past(count) == FULLC)); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout))); // R9
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
#(
  parameter int               FIFO_DEPTH = 4,
  parameter logic [NIB_W-1:0] SFD_LO     = 4'h5,
  parameter logic [NIB_W-1:0] SFD_HI     = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mii_dv,
  input  logic [NIB_W-1:0]  mii_rxd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_err,
  output logic              ovf_drop
);
  logic     in_data;
  logic     push;
  rx_beat_t beat_in, beat_out;

  mii_sfd_hunt #(.SFD_LO(SFD_LO), .SFD_HI(SFD_HI)) u_hunt (
    .clk(clk), .rst_n(rst_n), .dv(mii_dv), .rxd(mii_rxd), .in_data(in_data)
  );

  mii_nib_pack u_pack (
    .clk(clk), .rst_n(rst_n), .dv(mii_dv), .in_data(in_data), .nib(mii_rxd),
    .push(push), .beat(beat_in)
  );

  mii_beat_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(beat_in),
    .out_valid(out_valid), .out_ready(out_ready), .dout(beat_out),
    .ovf_drop(ovf_drop)
  );

  assign out_data = beat_out.data;
  assign out_sof  = beat_out.sof;
  assign out_eof  = beat_out.eof;
  assign out_err  = beat_out.err;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !ovf_drop)); // R1
endmodule

// File: tb/mii_rx_framer_tb.sv
module mii_rx_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mii_dv = 1'b0;
  logic [3:0] mii_rxd = 4'h0;
  logic       out_valid, out_ready, out_sof, out_eof, out_err, ovf_drop;
  logic [7:0] out_data;

  int checks = 0, errors = 0, ovf_cnt = 0, rdy_mode = 1;
  bit mon_en = 0, done = 0, held = 0, last_low = 0;
  logic [10:0] held_beat;
  logic [10:0] exp_q[$];
  logic [3:0]  frm[$];

  mii_rx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .mii_dv(mii_dv), .mii_rxd(mii_rxd),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err), .ovf_drop(ovf_drop)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ready: 0 = held low, 1 = held high, 2 = random, never low twice in a row
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: begin
        out_ready = last_low ? 1'b1 : (($urandom % 4) != 0);
        last_low  = !out_ready;
      end
    endcase
  end

  always @(negedge clk) begin
    if (mon_en) begin
      logic [10:0] cur;
      cur = {out_data, out_sof, out_eof, out_err};
      if (ovf_drop) ovf_cnt++;
      if (held) check("R9 held beat", {31'd0, out_valid} << 11 | cur, {20'd1, held_beat});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R3 unexpected beat", 1, 0);
        else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          check("R2 data byte", cur[10:3], e[10:3]);
          check("R5 sof", cur[2], e[2]);
          check("R6 eof", cur[1], e[1]);
          check("R7 err", cur[0], e[0]);
        end
      end
      held      = out_valid && !out_ready;
      held_beat = cur;
    end
  end

  // expected beats of one frame, straight from the requirements
  task automatic model_frame();
    int st = 0;  // 0 search, 1 after 0x5, 2 data, 3 aborted
    logic prev = 1'b1;
    logic [3:0] d[$];
    int nb;
    foreach (frm[k]) begin
      logic [3:0] n;
      n = frm[k];
      if (st == 2) d.push_back(n);
      else if (st != 3) begin
        logic bad = 1'b0;
        logic b = prev;
        for (int i = 0; i < 4; i++) begin
          if (!b && !n[i]) bad = 1'b1;
          b = n[i];
        end
        if (bad) st = 3;
        else if (st == 1 && n == 4'hD) st = 2;
        else if (n == 4'h5) st = 1;
        else st = 0;
      end
      prev = n[3];
    end
    nb = d.size() / 2;
    for (int j = 0; j < nb; j++)
      exp_q.push_back({d[2*j+1], d[2*j], 1'(j == 0), 1'(j == nb - 1),
                       1'((j == nb - 1) && (d.size() % 2 == 1))});
  endtask

  task automatic send_frame(input int gap);
    foreach (frm[k]) begin
      mii_dv = 1'b1; mii_rxd = frm[k];
      @(posedge clk); #1;
    end
    mii_dv = 1'b0; mii_rxd = 4'h0;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  task automatic run(input int gap);
    model_frame();
    send_frame(gap);
  endtask

  task automatic sfd_then(input int pre, input int ndat);
    frm.delete();
    repeat (pre) frm.push_back(4'h5);
    frm.push_back(4'h5); frm.push_back(4'hD);
    repeat (ndat) frm.push_back(4'($urandom));
  endtask

  task automatic drain_check(input string tag);
    repeat (12) @(posedge clk);
    #1;
    check(tag, exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 ovf_drop after reset", ovf_drop, 0);
    mon_en = 1;
    @(posedge clk); #1;

    // R3 zero preamble, R2 nibble order: bytes 0xC3, 0x7E, 0xA1
    frm = '{4'h5, 4'hD, 4'h3, 4'hC, 4'hE, 4'h7, 4'h1, 4'hA};
    run(3); drain_check("R3 zero preamble frame done");
    // R3 long preamble
    sfd_then(15, 8); run(3); drain_check("R3 long preamble frame done");
    // R4 00 inside a nibble, then an SFD later: no beats
    frm = '{4'h5, 4'h4, 4'h5, 4'hD, 4'h3, 4'h3};
    run(2); drain_check("R4 inner 00 abort");
    // R4 00 across a nibble boundary (0x5 msb 0, 0xA lsb 0)
    frm = '{4'h5, 4'hA, 4'h5, 4'hD, 4'h9, 4'h9};
    run(1); drain_check("R4 boundary 00 abort");
    // R8 aborted frame then good frame after one idle cycle
    frm = '{4'h0, 4'h5, 4'hD, 4'h1, 4'h2}; run(1);
    sfd_then(2, 6); run(1);
    sfd_then(0, 4); run(3); drain_check("R8 back to back frames");
    // R7 odd trailing nibble, and a lone nibble after SFD
    sfd_then(1, 7); run(3);
    sfd_then(1, 1); run(3); drain_check("R7 odd nibble frames");
    // R11 stray 0xD and clean junk nibbles keep the search alive
    frm = '{4'hD, 4'hF, 4'h7, 4'hB, 4'h5, 4'h5, 4'hD, 4'h6, 4'h6};
    run(3); drain_check("R11 junk before SFD");

    // R10 overflow: ten bytes against a stalled output
    rdy_mode = 0; ovf_cnt = 0;
    @(posedge clk); #1;
    sfd_then(3, 20);
    model_frame();
    while (exp_q.size() > 4) void'(exp_q.pop_back());
    send_frame(6);
    @(negedge clk);
    check("R10 dropped beat pulses", ovf_cnt, 6);
    check("R9 valid while stalled", out_valid, 1);
    check("R10 head is first byte", out_data, exp_q[0][10:3]);
    @(posedge clk); #1 rdy_mode = 1;
    drain_check("R10 kept beats delivered");

    // random traffic
    rdy_mode = 2;
    for (int f = 0; f < 200; f++) begin
      int kind;
      kind = $urandom % 4;
      frm.delete();
      if (kind == 2) repeat ($urandom % 4) frm.push_back((($urandom % 2) != 0) ? 4'hF : 4'h7);
      repeat ($urandom % 8) frm.push_back(4'h5);
      if (kind == 1) frm.push_back(4'($urandom));
      frm.push_back(4'h5);
      frm.push_back((kind == 3) ? 4'($urandom) : 4'hD);
      repeat ($urandom % 20) frm.push_back(4'($urandom));
      run(1 + $urandom % 4);
    end
    drain_check("R6 random frames all delivered");
    check("R10 no drops in random traffic", ovf_cnt, 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule